// File: doc/BRIEF.md
# Hardware Address Breakpoint Unit

This unit watches the address bus of a small 8-bit processor with a 16-bit address space. When the bus address equals a programmed break address and breaking is switched on, it asks the processor to enter a break interrupt. Software can also force a break by writing the status bit. The break address sits in two byte registers, one for the upper byte and one for the lower byte. A control/status byte holds an enable bit and an active bit. All three registers are reached through a simple byte-wide register port.

A break request is raised only on the last cycle of an instruction. A match on that last cycle is requested in the same cycle. A match on any earlier cycle is held in a pending flag, and that flag requests the break at the next instruction boundary. The processor's acknowledge clears the flag. The unit also supplies the vector address to fetch, which depends on whether the processor runs in monitor mode. While the active bit is set, the unit freezes the timer and, under the right conditions, disables the watchdog.

Top module: `brkpt_unit`

## Requirements
- R1: After synchronous reset, all three registers read 0x00, and brk_req, tmr_freeze and wdog_inhibit are 0.
- R2: Register select 1 reads and writes the break address upper byte and select 2 the lower byte. Select 0 is the control byte, with enable in bit 7 and active in bit 6; bits 5..0 read 0. Select 3 reads 0x00 and writes have no effect. Reads are combinational, and writes take effect at the clock edge.
- R3: A match is a cycle in which enable is 1, bus_valid is 1 and all 16 bits of bus_addr equal {upper,lower}. A match sets the active bit at the next edge. No match occurs when enable is 0, when bus_valid is 0, or when either byte differs.
- R4: brk_req is high only in cycles where instr_last is 1. A match in a cycle with instr_last=1 raises brk_req in that same cycle.
- R5: A match in a cycle with instr_last=0 does not raise brk_req in that cycle. The match sets a pending flag, and brk_req is then 1 in every later cycle with instr_last=1, until a cycle with brk_ack=1. That cycle clears the flag, and the acknowledge wins over a set in the same cycle.
- R6: Writing the control byte with bit 6 = 1 sets the active bit and the pending flag, even with enable = 0, so brk_req follows at the next cycle with instr_last=1.
- R7: Writing the control byte with bit 6 = 0 clears the active bit. When a match happens in the same cycle, the active bit is set instead.
- R8: vec_addr is 16'hFEFC when monitor_mode=1 and 16'hFFFC otherwise.
- R9: tmr_freeze equals the current active bit.
- R10: wdog_inhibit is 1 only when the active bit, monitor_mode and wdog_brk_dis are all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 control, 1 upper address byte, 2 lower address byte, 3 none |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| bus_addr | input | 16 | Processor bus address |
| bus_valid | input | 1 | Bus address is valid this cycle |
| instr_last | input | 1 | Current cycle is the last cycle of an instruction |
| brk_ack | input | 1 | Processor takes the break this cycle |
| monitor_mode | input | 1 | Processor runs in monitor mode |
| wdog_brk_dis | input | 1 | Auxiliary bit allowing watchdog disable during a break |
| brk_req | output | 1 | Break interrupt request, valid at instruction boundary |
| vec_addr | output | 16 | Address of the break vector high byte |
| tmr_freeze | output | 1 | Hold the timer counter |
| wdog_inhibit | output | 1 | Disable the watchdog |

## Verification
On every cycle the assertions check four things. A request appears only on a last cycle. The pending flag holds until an acknowledge clears it. A same-cycle match beats a software clear of the active bit, and the watchdog inhibit implies both freeze and monitor mode. Only the bench scenarios can show the rest. That covers the full 16-bit compare with each byte differing, the deferral of an early-cycle match to a later boundary, the software-forced break with enable off, and the vector and register readback values.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;
    localparam int EN_POS = BYTE_W - 1;
    localparam int ACT_POS = BYTE_W - 2;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_AHI  = 2'd1,
        SEL_ALO  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef struct packed {
        logic en;
        logic act;
    } ctrl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } baddr_t;

    function automatic logic [BYTE_W-1:0] ctrl_byte(input ctrl_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[EN_POS] = c.en;
        b[ACT_POS] = c.act;
        return b;
    endfunction

    function automatic logic [ADDR_W-1:0] pick_vec(input logic mon,
                                                   input logic [ADDR_W-1:0] nrm,
                                                   input logic [ADDR_W-1:0] mnv);
        return mon ? mnv : nrm;
    endfunction

endpackage

// File: rtl/brkpt_regs.sv
module brkpt_regs
    import brkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              hw_set,
    output ctrl_t             ctrl_q,
    output baddr_t            addr_q,
    output logic [BYTE_W-1:0] rdata,
    output logic              sw_set
);

    sel_e  sel_v;
    ctrl_t ctrl_d;
    logic  ctrl_wr;

    assign sel_v   = sel_e'(sel);
    assign ctrl_wr = wr && (sel_v == SEL_CTRL);
    assign sw_set  = ctrl_wr && wdata[ACT_POS];

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d.en  = wdata[EN_POS];
            ctrl_d.act = wdata[ACT_POS];
        end
        if (hw_set) ctrl_d.act = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            addr_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (wr && sel_v == SEL_AHI) addr_q.hi <= wdata;
            if (wr && sel_v == SEL_ALO) addr_q.lo <= wdata;
        end
    end

    always_comb begin
        unique case (sel_v)
            SEL_CTRL: rdata = ctrl_byte(ctrl_q);
            SEL_AHI:  rdata = addr_q.hi;
            SEL_ALO:  rdata = addr_q.lo;
            default:  rdata = '0;
        endcase
    end

    // R7: a hardware match beats any software write of the active bit
    p_hwset_wins_r7: assert property (@(posedge clk) disable iff (rst)
        hw_set |=> ctrl_q.act);

    // R7: a software clear without a match drops the active bit
    p_swclr_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wdata[ACT_POS] && !hw_set) |=> !ctrl_q.act);

endmodule

// File: rtl/brkpt_match.sv
module brkpt_match
    import brkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl_q,
    input  baddr_t            addr_q,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_valid,
    input  logic              instr_last,
    input  logic              brk_ack,
    input  logic              sw_set,
    output logic              hit,
    output logic              brk_req
);

    logic pend_q;
    logic pend_d;

    assign hit     = ctrl_q.en && bus_valid && (bus_addr == addr_q);
    assign brk_req = instr_last && (pend_q || hit);

    always_comb begin
        if (brk_ack) pend_d = 1'b0;
        else         pend_d = pend_q || hit || sw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= pend_d;
    end

    // R4: a request is raised only at an instruction boundary
    p_req_last_r4: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> instr_last);

    // R5: a pending break waits until acknowledged
    p_pend_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !brk_ack) |=> pend_q);

    // R5: acknowledge clears the pending flag
    p_ack_clr_r5: assert property (@(posedge clk) disable iff (rst)
        brk_ack |=> !pend_q);

endmodule

// File: rtl/brkpt_side.sv
module brkpt_side
    import brkpt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_NORMAL  = 16'hFFFC,
    parameter logic [ADDR_W-1:0] VEC_MONITOR = 16'hFEFC
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl_q,
    input  logic              monitor_mode,
    input  logic              wdog_brk_dis,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              tmr_freeze,
    output logic              wdog_inhibit
);

    assign vec_addr     = pick_vec(monitor_mode, VEC_NORMAL, VEC_MONITOR);
    assign tmr_freeze   = ctrl_q.act;
    assign wdog_inhibit = ctrl_q.act && monitor_mode && wdog_brk_dis;

    // R10: watchdog inhibit only inside a frozen break in monitor mode
    p_inhibit_r10: assert property (@(posedge clk) disable iff (rst)
        wdog_inhibit |-> (tmr_freeze && monitor_mode));

endmodule

// File: rtl/brkpt_unit.sv
module brkpt_unit
    import brkpt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_NORMAL  = 16'hFFFC,
    parameter logic [ADDR_W-1:0] VEC_MONITOR = 16'hFEFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_valid,
    input  logic              instr_last,
    input  logic              brk_ack,
    input  logic              monitor_mode,
    input  logic              wdog_brk_dis,
    output logic              brk_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              tmr_freeze,
    output logic              wdog_inhibit
);

    ctrl_t  ctrl_q;
    baddr_t addr_q;
    logic   hit;
    logic   sw_set;

    brkpt_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .hw_set (hit),
        .ctrl_q (ctrl_q),
        .addr_q (addr_q),
        .rdata  (reg_rdata),
        .sw_set (sw_set)
    );

    brkpt_match u_match (
        .clk        (clk),
        .rst        (rst),
        .ctrl_q     (ctrl_q),
        .addr_q     (addr_q),
        .bus_addr   (bus_addr),
        .bus_valid  (bus_valid),
        .instr_last (instr_last),
        .brk_ack    (brk_ack),
        .sw_set     (sw_set),
        .hit        (hit),
        .brk_req    (brk_req)
    );

    brkpt_side #(
        .VEC_NORMAL  (VEC_NORMAL),
        .VEC_MONITOR (VEC_MONITOR)
    ) u_side (
        .clk          (clk),
        .rst          (rst),
        .ctrl_q       (ctrl_q),
        .monitor_mode (monitor_mode),
        .wdog_brk_dis (wdog_brk_dis),
        .vec_addr     (vec_addr),
        .tmr_freeze   (tmr_freeze),
        .wdog_inhibit (wdog_inhibit)
    );

endmodule

// File: tb/brkpt_unit_tb.sv
module brkpt_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_valid = 1'b0;
    logic        instr_last = 1'b0;
    logic        brk_ack = 1'b0;
    logic        monitor_mode = 1'b0;
    logic        wdog_brk_dis = 1'b0;
    logic        brk_req;
    logic [15:0] vec_addr;
    logic        tmr_freeze;
    logic        wdog_inhibit;

    always #5 clk = ~clk;

    brkpt_unit u_dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
        .bus_valid(bus_valid), .instr_last(instr_last), .brk_ack(brk_ack),
        .monitor_mode(monitor_mode), .wdog_brk_dis(wdog_brk_dis),
        .brk_req(brk_req), .vec_addr(vec_addr), .tmr_freeze(tmr_freeze),
        .wdog_inhibit(wdog_inhibit)
    );

    typedef struct {
        logic        req;
        logic        frz;
        logic        inh;
        logic [15:0] vec;
        logic [7:0]  rd;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    // reference state derived from the requirements
    logic       m_en = 1'b0, m_act = 1'b0, m_pend = 1'b0;
    logic [7:0] m_hi = 8'h00, m_lo = 8'h00;

    task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                       input string tag, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({15'd0, brk_req},      {15'd0, e.req}, e.tag, "brk_req");
            chk({15'd0, tmr_freeze},   {15'd0, e.frz}, e.tag, "tmr_freeze");
            chk({15'd0, wdog_inhibit}, {15'd0, e.inh}, e.tag, "wdog_inhibit");
            chk(vec_addr,              e.vec,          e.tag, "vec_addr");
            chk({8'd0, reg_rdata},     {8'd0, e.rd},   e.tag, "reg_rdata");
        end
    end

    task automatic cyc(input logic [1:0] sel, input logic wr, input logic [7:0] wd,
                       input logic [15:0] a, input logic v, input logic lst,
                       input logic ack, input logic mon, input logic dis,
                       input string tag);
        exp_t e;
        logic hit;
        reg_sel = sel; reg_wr = wr; reg_wdata = wd; bus_addr = a;
        bus_valid = v; instr_last = lst; brk_ack = ack;
        monitor_mode = mon; wdog_brk_dis = dis;
        hit = m_en && v && (a == {m_hi, m_lo});
        e.req = lst && (m_pend || hit);
        e.frz = m_act;
        e.inh = m_act && mon && dis;
        e.vec = mon ? 16'hFEFC : 16'hFFFC;
        case (sel)
            2'd0: e.rd = {m_en, m_act, 6'b0};
            2'd1: e.rd = m_hi;
            2'd2: e.rd = m_lo;
            default: e.rd = 8'h00;
        endcase
        e.tag = tag;
        q.push_back(e);
        if (ack) m_pend = 1'b0;
        else m_pend = m_pend || hit || (wr && sel == 2'd0 && wd[6]);
        if (wr && sel == 2'd0) begin m_en = wd[7]; m_act = wd[6]; end
        if (wr && sel == 2'd1) m_hi = wd;
        if (wr && sel == 2'd2) m_lo = wd;
        if (hit) m_act = 1'b1;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state of every register and output
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 0, 0, 0, 0, "R1");
        cyc(2'd1, 0, 8'h00, 16'h0000, 0, 0, 0, 0, 0, "R1");
        cyc(2'd2, 0, 8'h00, 16'h0000, 0, 0, 0, 0, 0, "R1");
        // R2: register write and readback
        cyc(2'd1, 1, 8'h12, 16'h0000, 0, 0, 0, 0, 0, "R2");
        cyc(2'd2, 1, 8'h34, 16'h0000, 0, 0, 0, 0, 0, "R2");
        cyc(2'd1, 0, 8'h00, 16'h0000, 0, 0, 0, 0, 0, "R2");
        cyc(2'd2, 0, 8'h00, 16'h0000, 0, 0, 0, 0, 0, "R2");
        cyc(2'd3, 1, 8'hFF, 16'h0000, 0, 0, 0, 0, 0, "R2");
        cyc(2'd1, 0, 8'h00, 16'h0000, 0, 0, 0, 0, 0, "R2");
        // R3: enable off, no break on matching address
        cyc(2'd0, 0, 8'h00, 16'h1234, 1, 1, 0, 0, 0, "R3");
        cyc(2'd0, 1, 8'hBF, 16'h0000, 0, 0, 0, 0, 0, "R2");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 0, 0, 0, 0, "R2");
        // R3: mismatch in either byte, or no valid strobe
        cyc(2'd0, 0, 8'h00, 16'h1235, 1, 1, 0, 0, 0, "R3");
        cyc(2'd0, 0, 8'h00, 16'h1334, 1, 1, 0, 0, 0, "R3");
        cyc(2'd0, 0, 8'h00, 16'h1234, 0, 1, 0, 0, 0, "R3");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 0, 0, 0, 0, "R3");
        // R5: early-cycle match defers to the boundary
        cyc(2'd0, 0, 8'h00, 16'h1234, 1, 0, 0, 0, 0, "R5");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 0, 0, 0, 0, "R9");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 1, 0, 0, 0, "R5");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 1, 1, 0, 0, "R5");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 1, 0, 0, 0, "R5");
        // R7: software clear of the active bit
        cyc(2'd0, 1, 8'h80, 16'h0000, 0, 0, 0, 0, 0, "R7");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 0, 0, 0, 0, "R7");
        // R4: match on last cycle is requested immediately
        cyc(2'd0, 0, 8'h00, 16'h1234, 1, 1, 1, 0, 0, "R4");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 1, 0, 0, 0, "R4");
        // R7: clear with a same-cycle match keeps the bit
        cyc(2'd0, 1, 8'h80, 16'h1234, 1, 1, 1, 0, 0, "R7");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 0, 0, 0, 0, "R7");
        cyc(2'd0, 1, 8'h00, 16'h0000, 0, 0, 0, 0, 0, "R7");
        // R6: software-forced break with enable off
        cyc(2'd0, 1, 8'h40, 16'h0000, 0, 0, 0, 0, 0, "R6");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 0, 0, 0, 0, "R6");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 1, 1, 0, 0, "R6");
        // R8 and R10: monitor vector and watchdog inhibit
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 0, 0, 1, 0, "R8");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 0, 0, 1, 1, "R10");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 0, 0, 0, 1, "R10");
        cyc(2'd0, 1, 8'h00, 16'h0000, 0, 0, 0, 1, 1, "R10");
        cyc(2'd0, 0, 8'h00, 16'h0000, 0, 0, 0, 1, 1, "R10");
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule